// File: doc/BRIEF.md
# Presettable Synchronous Up/Down Binary Counter

This block is a binary counter whose bits all change on the same rising clock edge. Each bit flips only when every lower bit is 1 (counting up) or every lower bit is 0 (counting down). That keeps the outputs free of the intermediate values that appear in a chain of cascaded toggle stages. A direction input picks up or down counting. An active-low enable freezes the count without losing it.

Two active-low asynchronous controls act without waiting for a clock edge. The first is a parallel preset that copies the data inputs into the count. The second is a clear that forces the count to zero. Clear wins over preset, and preset wins over counting.

A terminal-count flag marks the last value in the current direction. An active-low ripple-carry output pulses once per wrap, during the low phase of the clock. That pulse is meant to clock the next, more significant counter, so two copies chained together form a wider counter.

Top module: `sync_updn_counter`

## Requirements
- R1: With `up_i`=1 (up), `en_n_i`=0, `load_n_i`=1 and `clr_n_i`=1, each rising clock edge adds one to `q_o` (bit 0 is the least significant bit), and 15 wraps to 0.
- R2: With `up_i`=0 (down) under the same conditions, each rising clock edge subtracts one from `q_o`, and 0 wraps to 15.
- R3: While `en_n_i`=1, clock edges leave `q_o` unchanged; counting resumes from the held value when `en_n_i` returns to 0.
- R4: While `load_n_i`=0 and `clr_n_i`=1, `q_o` equals `d_i` immediately, with no clock edge needed. It follows changes on `d_i` for as long as the load is held, and it overrides counting.
- R5: While `clr_n_i`=0, `q_o` is 0 immediately, whatever the clock, load, data or enable inputs are doing.
- R6: `tc_o` is 1 exactly when `q_o`=15 with `up_i`=1, or when `q_o`=0 with `up_i`=0, regardless of `en_n_i`.
- R7: `rc_n_o` is 0 only while `tc_o`=1, `en_n_i`=0 and `clk` is low; it is 1 at all other times.
- R8: When a second counter is clocked by the first counter's `rc_n_o`, with its enable active and direction up, the pair counts in binary from 0 to 255 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; rising edge active |
| clr_n_i | input | 1 | Asynchronous clear, active low; highest priority |
| load_n_i | input | 1 | Asynchronous parallel preset, active low |
| en_n_i | input | 1 | Count enable, active low; 1 holds the count |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| d_i | input | WIDTH | Preset value |
| q_o | output | WIDTH | Present count |
| tc_o | output | 1 | Terminal count for the current direction |
| rc_n_o | output | 1 | Active-low ripple carry, low-clock-phase pulse at terminal count |

## Verification
Count results and the terminal-count flag are due one rising edge after the enable and direction that produced them. The bench therefore checks them 5 ns after each rising edge, against a behavioural integer model advanced at that same edge.

Preset and clear results need no edge at all. They are checked 1 ns after the control or data input moves, while the clock stays low, so that no clock edge can explain the change. The ripple carry depends on the clock phase. It is checked 5 ns after the rising edge, where it must be high, and again 2 ns after the falling edge, where it is compared with the model's terminal count and enable.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Per-bit asynchronous force pair, both active low
    typedef struct packed {
        logic set_n;
        logic rst_n;
    } force_ctl_t;

    // Build the force pair for one bit: clear outranks preset
    function automatic force_ctl_t make_force(input logic clr_n,
                                              input logic load_n,
                                              input logic dbit);
        force_ctl_t f;
        f.rst_n = clr_n & ~(~load_n & ~dbit);
        f.set_n = ~(clr_n & ~load_n & dbit);
        return f;
    endfunction

endpackage

// File: rtl/updn_toggle_chain.sv
module updn_toggle_chain
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q_i,
    input  dir_e             dir_i,
    input  logic             cnt_en_i,
    output logic [WIDTH-1:0] tog_o
);

    assign tog_o[0] = cnt_en_i;

    for (genvar i = 1; i < WIDTH; i++) begin : g_stage
        // Up: all lower bits 1; down: all lower bits 0
        assign tog_o[i] = tog_o[i-1] &
                          ((dir_i == DIR_UP) ? q_i[i-1] : ~q_i[i-1]);
    end

endmodule

// File: rtl/updn_bit_cell.sv
module updn_bit_cell (
    input  logic clk,
    input  logic set_n_i,
    input  logic rst_n_i,
    input  logic tog_i,
    output logic q_o
);

    always_ff @(posedge clk or negedge rst_n_i or negedge set_n_i) begin
        if (!rst_n_i) begin
            q_o <= 1'b0;
        end else if (!set_n_i) begin
            q_o <= 1'b1;
        end else if (tog_i) begin
            q_o <= ~q_o;
        end
    end

endmodule

// File: rtl/updn_cascade.sv
module updn_cascade
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] q_i,
    input  dir_e             dir_i,
    input  logic             cnt_en_i,
    output logic             tc_o,
    output logic             rc_n_o
);

    logic at_top;
    logic at_bottom;

    assign at_top    = &q_i;
    assign at_bottom = ~|q_i;
    assign tc_o      = (dir_i == DIR_UP) ? at_top : at_bottom;

    // One low-phase pulse per wrap; its rising edge meets the next rising clock
    assign rc_n_o = ~(tc_o & cnt_en_i & ~clk);

endmodule

// File: rtl/sync_updn_counter.sv
module sync_updn_counter
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n_i,
    input  logic             load_n_i,
    input  logic             en_n_i,
    input  logic             up_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o,
    output logic             tc_o,
    output logic             rc_n_o
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    dir_e             dir;
    logic             cnt_en;
    logic [WIDTH-1:0] tog;
    force_ctl_t       fctl [WIDTH];

    assign dir    = dir_e'(up_i);
    assign cnt_en = ~en_n_i;

    updn_toggle_chain #(.WIDTH(WIDTH)) u_chain (
        .q_i      (q_o),
        .dir_i    (dir),
        .cnt_en_i (cnt_en),
        .tog_o    (tog)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign fctl[i] = make_force(clr_n_i, load_n_i, d_i[i]);

        updn_bit_cell u_cell (
            .clk     (clk),
            .set_n_i (fctl[i].set_n),
            .rst_n_i (fctl[i].rst_n),
            .tog_i   (tog[i]),
            .q_o     (q_o[i])
        );
    end

    updn_cascade #(.WIDTH(WIDTH)) u_casc (
        .clk      (clk),
        .q_i      (q_o),
        .dir_i    (dir),
        .cnt_en_i (cnt_en),
        .tc_o     (tc_o),
        .rc_n_o   (rc_n_o)
    );

    // R1: enabled up count adds one per edge
    p_up_step_r1: assert property (@(posedge clk) disable iff (!clr_n_i || !load_n_i)
        (!en_n_i && up_i) |=> (q_o == $past(q_o) + ONE));

    // R2: enabled down count subtracts one per edge
    p_down_step_r2: assert property (@(posedge clk) disable iff (!clr_n_i || !load_n_i)
        (!en_n_i && !up_i) |=> (q_o == $past(q_o) - ONE));

    // R3: disabled count holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!clr_n_i || !load_n_i)
        en_n_i |=> $stable(q_o));

    // R4: preset held across an edge shows the data inputs
    p_load_r4: assert property (@(posedge clk)
        (clr_n_i && !load_n_i) |-> (q_o == d_i));

    // R5: clear held across an edge shows zero
    p_clear_r5: assert property (@(posedge clk)
        !clr_n_i |-> (q_o == '0));

    // R6: terminal count going up is followed by zero
    p_wrap_up_r6: assert property (@(posedge clk) disable iff (!clr_n_i || !load_n_i)
        (tc_o && up_i && !en_n_i) |=> (q_o == '0));

    // R6: terminal count going down is followed by all ones
    p_wrap_down_r6: assert property (@(posedge clk) disable iff (!clr_n_i || !load_n_i)
        (tc_o && !up_i && !en_n_i) |=> (q_o == TOP));

endmodule

// File: tb/sync_updn_counter_tb.sv
module sync_updn_counter_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n, load_n, en_n, up;
    logic [W-1:0] d;
    logic [W-1:0] q;
    logic         tc, rc_n;

    logic         c_clr_n;
    logic [W-1:0] lo_q, hi_q;
    logic         lo_tc, hi_tc, lo_rc_n, hi_rc_n;

    int n_run  = 0;
    int n_fail = 0;
    int exp_q  = 0;

    always #10 clk = ~clk;

    sync_updn_counter #(.WIDTH(W)) u_dut (
        .clk(clk), .clr_n_i(clr_n), .load_n_i(load_n), .en_n_i(en_n),
        .up_i(up), .d_i(d), .q_o(q), .tc_o(tc), .rc_n_o(rc_n)
    );

    sync_updn_counter #(.WIDTH(W)) u_lo (
        .clk(clk), .clr_n_i(c_clr_n), .load_n_i(1'b1), .en_n_i(1'b0),
        .up_i(1'b1), .d_i('0), .q_o(lo_q), .tc_o(lo_tc), .rc_n_o(lo_rc_n)
    );

    sync_updn_counter #(.WIDTH(W)) u_hi (
        .clk(lo_rc_n), .clr_n_i(c_clr_n), .load_n_i(1'b1), .en_n_i(1'b0),
        .up_i(1'b1), .d_i('0), .q_o(hi_q), .tc_o(hi_tc), .rc_n_o(hi_rc_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_tc();
        return (up && exp_q == 15) || (!up && exp_q == 0);
    endfunction

    // One clock: advance the model at the rising edge, check both phases
    task automatic step(input string tag);
        @(posedge clk);
        if (!clr_n)       exp_q = 0;
        else if (!load_n) exp_q = int'(d);
        else if (!en_n)   exp_q = up ? (exp_q + 1) % 16 : (exp_q + 15) % 16;
        #5;
        check(tag, int'(q), exp_q);
        check("R6 tc", int'(tc), exp_tc());
        check("R7 rc high phase", int'(rc_n), 1);
        @(negedge clk);
        #2;
        check("R7 rc low phase", int'(rc_n), (exp_tc() && !en_n) ? 0 : 1);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clr_n = 1'b0; load_n = 1'b1; en_n = 1'b1; up = 1'b1; d = '0;
        c_clr_n = 1'b0;
        #1;
        check("R5 reset", int'(q), 0);
        exp_q = 0;
        step("R5 held clear");
        step("R5 held clear");

        // Up count across a wrap
        clr_n = 1'b1; en_n = 1'b0; up = 1'b1;
        for (int i = 0; i < 20; i++) step("R1 up");
        while (exp_q != 15) step("R1 up");

        // Hold at terminal count: rc must stay high
        en_n = 1'b1;
        for (int i = 0; i < 4; i++) step("R3 hold");
        en_n = 1'b0;
        step("R3 resume wrap");

        // Down count across a wrap
        up = 1'b0;
        for (int i = 0; i < 20; i++) step("R2 down");
        en_n = 1'b1;
        step("R3 hold down");
        step("R3 hold down");
        en_n = 1'b0;

        // Asynchronous preset, data followed while held
        d = 4'd9; load_n = 1'b0; #1;
        check("R4 async load", int'(q), 9);
        d = 4'd5; #1;
        check("R4 load follows d", int'(q), 5);
        exp_q = 5;
        step("R4 load over count");
        load_n = 1'b1;
        step("R2 after load");

        // Preset at varied points, varied direction
        for (int k = 0; k < 6; k++) begin
            d = W'($urandom_range(0, 15));
            load_n = 1'b0; #1;
            check("R4 load mid count", int'(q), int'(d));
            exp_q = int'(d);
            step("R4 load edge");
            load_n = 1'b1;
            up = k[0];
            for (int j = 0; j < 5; j++) step(up ? "R1 after load" : "R2 after load");
        end

        // Clear outranks preset
        d = 4'd12; load_n = 1'b0; clr_n = 1'b0; #1;
        check("R5 clear over load", int'(q), 0);
        exp_q = 0;
        step("R5 clear over load edge");
        clr_n = 1'b1; #1;
        check("R4 load after clear", int'(q), 12);
        exp_q = 12;
        step("R4 held load");
        load_n = 1'b1;
        up = 1'b1;
        for (int i = 0; i < 5; i++) step("R1 resume");

        // Two-stage chain to 255 and wrap
        @(negedge clk);
        c_clr_n = 1'b1;
        for (int k = 1; k <= 256; k++) begin
            @(posedge clk);
            #5;
            check("R8 cascade", int'({hi_q, lo_q}), k % 256);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule